// File: doc/BRIEF.md
# Serial-Configured Single-Bit Fault Injector

This block sits across a group of single-bit functional signals and can invert exactly one of them to mimic a gate-level fault. It is set up over a small four-wire serial port (select, clock, data in, data out) that is sampled in the system clock domain and has no path into the functional signals other than the per-bit inversion itself. Setting up a fault therefore leaves the design under test untouched until the fault fires.

A frame chooses the point to corrupt, a solid or transient fault type, and a 16-bit seed. Once armed, a 16-bit LFSR loaded from the seed steps every system cycle. The fault fires on the first cycle its low bits read zero, so the moment of insertion has nothing to do with the activity of the surrounding logic. A solid fault stays until the next applied frame. A transient fault is dropped on its own as soon as the error-detected input is seen. A status word, shifted out during the next frame, reports the state and the number of LFSR steps taken before the fault fired.

Top module: `fault_inject_ctrl`

## Requirements
- R1: A frame is 24 bits sent MSB first and captured on rising serial clock edges while select is low. Its bit 23 is enable, bit 22 is mode (1 = transient, 0 = solid), bits 21:16 are the point index and bits 15:0 are the seed. It takes effect when select rises, and only if exactly 24 clock edges were seen; any other count leaves all state unchanged.
- R2: When select falls, the 24-bit status is loaded and shifted out MSB first on the data-out pin, one new bit after each rising serial clock edge. Bit 23 is armed, bit 22 is injected, bit 21 is released, bit 20 is bad index, bits 19:16 are zero, and bits 15:0 are the step count.
- R3: A frame with enable 0 and mode 1 is a query that changes no state. A frame with enable 0 and mode 0 disarms: any fault is removed, and the flags and step count are cleared.
- R4: An enabled frame whose index is not below NUM_POINTS arms nothing and sets the bad index flag. The next applied frame clears the flag.
- R5: On arming, the LFSR loads the seed, or 1 if the seed is 0. It steps as s <= {s[14:0], s[15]^s[13]^s[12]^s[10]} each cycle until its low DELAY_W bits are zero. The fault then appears SYNC_STAGES+2+N clock edges after select rises, where N is the number of steps taken, and the step count reads N.
- R6: At most one output bit differs from its input, and only the bit at the armed index. With no fault, the outputs equal the inputs.
- R7: A solid fault stays applied whatever the error-detected input does, until the next arming or disarming frame.
- R8: A transient fault is removed one cycle after error-detected is sampled high while the fault is applied, and the released flag is set. Error-detected before injection has no effect.
- R9: An enabled frame applied while a fault is active removes that fault and restarts the delay for the newly chosen point.
- R10: After reset, no output is corrupted and the status reads all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sclk | input | 1 | Serial shift clock |
| cfg_sel_n | input | 1 | Serial frame select, active low |
| cfg_mosi | input | 1 | Serial data into the block |
| cfg_miso | output | 1 | Serial status out of the block |
| err_detect | input | 1 | Error reported by the protected logic |
| func_in | input | NUM_POINTS | Functional bits before the insertion points |
| func_out | output | NUM_POINTS | Functional bits after the insertion points |

## Verification
On every cycle, the assertions check that at most one bit is inverted and that a fault only exists while armed. They check that a solid fault holds and a transient fault drops after an error report, that a query keeps the armed and bad index state, that a bad index never arms, and that no fault is visible in the cycle right after a frame is applied. Only the bench scenarios can show the exact insertion cycle predicted from the seed, the status bit layout and step count, the rejection of frames with a wrong length, the move of a fault to a new point on re-arming, and the fact that error reports arriving before injection are ignored.

// File: rtl/fi_pkg.sv
package fi_pkg;

   localparam int FRAME_W = 24;
   localparam int SEED_W  = 16;
   localparam int IDX_W   = 6;

   typedef struct packed {
      logic              en;
      logic              transient;
      logic [IDX_W-1:0]  idx;
      logic [SEED_W-1:0] seed;
   } fi_frame_t;

   typedef struct packed {
      logic              armed;
      logic              injected;
      logic              released;
      logic              bad_idx;
      logic [3:0]        zero;
      logic [SEED_W-1:0] steps;
   } fi_status_t;

   function automatic logic [SEED_W-1:0] lfsr_advance(input logic [SEED_W-1:0] s);
      return {s[SEED_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

endpackage

// File: rtl/fi_serial_port.sv
module fi_serial_port
   import fi_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       sel_n,
   input  logic       mosi,
   output logic       miso,
   input  fi_status_t status_in,
   output fi_frame_t  frame_out,
   output logic       frame_valid
);

   localparam int CNT_W   = $clog2(FRAME_W + 2);
   localparam int CNT_MAX = FRAME_W + 1;

   logic [SYNC_STAGES-1:0][2:0] sync_q;
   logic                        sel_s, sclk_s, mosi_s;
   logic                        sel_d, sclk_d;
   logic                        sel_fall, sel_rise, sclk_rise;
   logic [FRAME_W-1:0]          shreg;
   logic [CNT_W-1:0]            edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{3'b100}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], {sel_n, sclk, mosi}};
   end

   assign sel_s  = sync_q[SYNC_STAGES-1][2];
   assign sclk_s = sync_q[SYNC_STAGES-1][1];
   assign mosi_s = sync_q[SYNC_STAGES-1][0];

   assign sel_fall  = !sel_s && sel_d;
   assign sel_rise  = sel_s && !sel_d;
   assign sclk_rise = sclk_s && !sclk_d && !sel_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_d    <= 1'b1;
         sclk_d   <= 1'b0;
         shreg    <= '0;
         edge_cnt <= '0;
      end else begin
         sel_d  <= sel_s;
         sclk_d <= sclk_s;
         if (sel_fall) begin
            shreg    <= status_in;
            edge_cnt <= '0;
         end else if (sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], mosi_s};
            if (edge_cnt != CNT_W'(CNT_MAX)) edge_cnt <= edge_cnt + 1'b1;
         end
      end
   end

   assign miso        = shreg[FRAME_W-1];
   assign frame_out   = fi_frame_t'(shreg);
   assign frame_valid = sel_rise && (edge_cnt == CNT_W'(FRAME_W));

endmodule

// File: rtl/fi_lfsr_timer.sv
module fi_lfsr_timer
   import fi_pkg::*;
#(
   parameter int DELAY_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SEED_W-1:0] seed,
   input  logic              run,
   output logic              hit,
   output logic [SEED_W-1:0] steps
);

   logic [SEED_W-1:0] lfsr_q;

   assign hit = (lfsr_q[DELAY_W-1:0] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lfsr_q <= SEED_W'(1);
         steps  <= '0;
      end else if (load) begin
         lfsr_q <= (seed == '0) ? SEED_W'(1) : seed;
         steps  <= '0;
      end else if (run && !hit) begin
         lfsr_q <= lfsr_advance(lfsr_q);
         if (steps != '1) steps <= steps + 1'b1;
      end
   end

endmodule

// File: rtl/fi_point_array.sv
module fi_point_array
   import fi_pkg::*;
#(
   parameter int NUM_POINTS = 16
) (
   input  logic [NUM_POINTS-1:0] func_in,
   input  logic [IDX_W-1:0]      sel_idx,
   input  logic                  active,
   output logic [NUM_POINTS-1:0] func_out
);

   generate
      for (genvar p = 0; p < NUM_POINTS; p++) begin : g_point
         logic flip;
         assign flip        = active && (sel_idx == IDX_W'(p));
         assign func_out[p] = flip ? ~func_in[p] : func_in[p];
      end
   endgenerate

endmodule

// File: rtl/fault_inject_ctrl.sv
module fault_inject_ctrl
   import fi_pkg::*;
#(
   parameter int NUM_POINTS  = 16,
   parameter int DELAY_W     = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_sclk,
   input  logic                  cfg_sel_n,
   input  logic                  cfg_mosi,
   output logic                  cfg_miso,
   input  logic                  err_detect,
   input  logic [NUM_POINTS-1:0] func_in,
   output logic [NUM_POINTS-1:0] func_out
);

   generate
      if (NUM_POINTS < 1 || NUM_POINTS > (1 << IDX_W)) begin : g_chk_points
         $error("NUM_POINTS must lie in 1..64");
      end
      if (DELAY_W < 1 || DELAY_W > SEED_W) begin : g_chk_delay
         $error("DELAY_W must lie in 1..16");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   fi_frame_t         frame;
   fi_status_t        status;
   logic              frame_valid;
   logic              is_query;
   logic              arm_load;
   logic              idx_ok;
   logic              armed, injected, released, bad_idx, mode_tr;
   logic [IDX_W-1:0]  point_idx;
   logic              hit;
   logic [SEED_W-1:0] steps;
   logic              fault_active;

   fi_serial_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk       (cfg_sclk),
      .sel_n      (cfg_sel_n),
      .mosi       (cfg_mosi),
      .miso       (cfg_miso),
      .status_in  (status),
      .frame_out  (frame),
      .frame_valid(frame_valid)
   );

   assign is_query = !frame.en && frame.transient;
   assign arm_load = frame_valid && !is_query;
   assign idx_ok   = (int'(frame.idx) < NUM_POINTS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         injected  <= 1'b0;
         released  <= 1'b0;
         bad_idx   <= 1'b0;
         mode_tr   <= 1'b0;
         point_idx <= '0;
      end else if (arm_load) begin
         armed     <= frame.en && idx_ok;
         injected  <= 1'b0;
         released  <= 1'b0;
         bad_idx   <= frame.en && !idx_ok;
         mode_tr   <= frame.transient;
         point_idx <= frame.idx;
      end else begin
         if (armed && !injected && hit) injected <= 1'b1;
         if (injected && !released && mode_tr && err_detect) released <= 1'b1;
      end
   end

   fi_lfsr_timer #(.DELAY_W(DELAY_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (arm_load),
      .seed (frame.seed),
      .run  (armed && !injected),
      .hit  (hit),
      .steps(steps)
   );

   assign fault_active = injected && !released;

   fi_point_array #(.NUM_POINTS(NUM_POINTS)) u_points (
      .func_in (func_in),
      .sel_idx (point_idx),
      .active  (fault_active),
      .func_out(func_out)
   );

   assign status = '{armed: armed, injected: injected, released: released,
                     bad_idx: bad_idx, zero: 4'b0000, steps: steps};

endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
   parameter int NUM_POINTS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_POINTS-1:0] func_in,
   input logic [NUM_POINTS-1:0] func_out,
   input logic                  err_detect,
   input logic                  frame_valid,
   input logic                  is_query,
   input logic                  arm_load,
   input logic                  frame_en,
   input logic                  idx_ok,
   input logic                  armed,
   input logic                  bad_idx,
   input logic                  mode_tr,
   input logic                  fault_active
);

   assert_one_hot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(func_out ^ func_in));

   assert_fault_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (func_out != func_in) |-> armed);

   assert_solid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_active && !mode_tr && !arm_load) |=> fault_active);

   assert_transient_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_active && mode_tr && err_detect && !arm_load) |=> !fault_active);

   assert_bad_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_load && frame_en && !idx_ok) |=> (!armed && bad_idx));

   assert_query_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && is_query) |=> ($stable(armed) && $stable(bad_idx)));

   assert_quiet_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arm_load |=> (func_out == func_in));

endmodule

bind fault_inject_ctrl fi_checker #(.NUM_POINTS(NUM_POINTS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .func_in     (func_in),
   .func_out    (func_out),
   .err_detect  (err_detect),
   .frame_valid (frame_valid),
   .is_query    (is_query),
   .arm_load    (arm_load),
   .frame_en    (frame.en),
   .idx_ok      (idx_ok),
   .armed       (armed),
   .bad_idx     (bad_idx),
   .mode_tr     (mode_tr),
   .fault_active(fault_active)
);

// File: tb/fault_inject_ctrl_tb.sv
module fault_inject_ctrl_tb;

   localparam int NP   = 16;
   localparam int DW   = 6;
   localparam int SYNC = 2;
   localparam int H    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sclk = 1'b0, sel_n = 1'b1, mosi = 1'b0;
   logic          miso;
   logic          err = 1'b0;
   logic [NP-1:0] fin = '0;
   logic [NP-1:0] fout;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #5 clk = ~clk;

   fault_inject_ctrl #(.NUM_POINTS(NP), .DELAY_W(DW), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_sclk(sclk), .cfg_sel_n(sel_n), .cfg_mosi(mosi),
      .cfg_miso(miso), .err_detect(err), .func_in(fin), .func_out(fout)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 150000)", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return (s << 1) | 16'(^(s & 16'hB400));
   endfunction

   function automatic int steps_for(input logic [15:0] seed);
      logic [15:0] s = (seed == 16'd0) ? 16'd1 : seed;
      int n = 0;
      while (s[DW-1:0] != '0 && n < 70000) begin
         s = lfsr_next(s);
         n++;
      end
      return n;
   endfunction

   function automatic logic [23:0] mk_frame(input logic en, input logic tr, input logic [5:0] idx,
                                            input logic [15:0] seed);
      return {en, tr, idx, seed};
   endfunction

   function automatic logic [NP-1:0] pmask(input int idx);
      return NP'(1) << idx;
   endfunction

   task automatic xfer(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
      rx = '0;
      @(negedge clk);
      sel_n = 1'b0;
      sclk  = 1'b0;
      repeat (2*H) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 24) ? tx[5'(23 - i)] : 1'b0;
         repeat (H) @(negedge clk);
         rx   = {rx[22:0], miso};
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (H) @(negedge clk);
      sel_n = 1'b1;
   endtask

   task automatic step_check(input logic [NP-1:0] mask, input string req);
      @(posedge clk);
      @(negedge clk);
      fin = NP'($urandom);
      #1;
      check(fout == (fin ^ mask), req, 32'(fout), 32'(fin ^ mask));
   endtask

   task automatic query_status(input logic [23:0] exp, input string req);
      logic [23:0] rx;
      xfer(mk_frame(1'b0, 1'b1, 6'd0, 16'd0), 24, rx);
      check(rx == exp, req, 32'(rx), 32'(exp));
   endtask

   // Arms a point and checks every cycle until the fault is seen. Returns the expected step count.
   task automatic arm_watch(input int idx, input logic [15:0] seed, input logic tr,
                            input logic early_err, input logic [NP-1:0] prev_mask, output int n);
      logic [23:0] rx;
      int lat;
      n = steps_for(seed);
      lat = n + SYNC + 2;
      xfer(mk_frame(1'b1, tr, 6'(idx), seed), 24, rx);
      err = early_err;
      for (int c = 1; c <= lat + 2; c++) begin
         if (c == lat - 1) err = 1'b0;
         if (c < SYNC + 1)
            step_check(prev_mask, "R9 old fault until apply");
         else if (c < lat)
            step_check('0, "R5 no fault before delay ends");
         else
            step_check(pmask(idx), "R5/R6 fault at predicted cycle");
      end
      err = 1'b0;
   endtask

   task automatic pulse_err(input logic tr, input int idx);
      @(negedge clk);
      err = 1'b1;
      step_check(tr ? '0 : pmask(idx), tr ? "R8 transient released" : "R7 solid holds on error");
      err = 1'b0;
      step_check(tr ? '0 : pmask(idx), tr ? "R8 stays released" : "R7 solid still held");
   endtask

   initial begin
      logic [23:0] rx;
      int n;
      logic [NP-1:0] cur;
      void'($urandom(32'd1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      for (int k = 0; k < 4; k++) step_check('0, "R10 no fault after reset");
      query_status(24'h000000, "R10/R2 status zero after reset");

      // R5/R7: solid, seed with zero low bits fires at once
      arm_watch(0, 16'h0040, 1'b0, 1'b0, '0, n);
      check(n == 0, "R5 zero-step seed", 32'(n), 32'd0);
      pulse_err(1'b0, 0);
      query_status({4'b1100, 4'b0, 16'(n)}, "R2/R7 status solid injected");
      step_check(pmask(0), "R3 query leaves fault in place");

      // R9: re-arm onto another point while the fault is active
      arm_watch(NP-1, 16'h0001, 1'b0, 1'b0, pmask(0), n);
      query_status({4'b1100, 4'b0, 16'(n)}, "R9/R5 step count after re-arm");

      // R3: disarm
      xfer(mk_frame(1'b0, 1'b0, 6'd3, 16'h1234), 24, rx);
      for (int c = 1; c <= 6; c++)
         step_check(c < SYNC + 1 ? pmask(NP-1) : '0, "R3 disarm removes fault");
      query_status(24'h000000, "R3 disarm clears status");

      // R4: index out of range
      xfer(mk_frame(1'b1, 1'b0, 6'(NP), 16'h0040), 24, rx);
      for (int c = 0; c < 40; c++) step_check('0, "R4 bad index arms nothing");
      query_status(24'h100000, "R4 bad index flag");

      // R1: wrong frame lengths are ignored
      xfer(mk_frame(1'b1, 1'b0, 6'd2, 16'h0040), 23, rx);
      for (int c = 0; c < 10; c++) step_check('0, "R1 short frame ignored");
      xfer(mk_frame(1'b1, 1'b0, 6'd2, 16'h0040), 25, rx);
      for (int c = 0; c < 10; c++) step_check('0, "R1 long frame ignored");
      query_status(24'h100000, "R1 status unchanged by bad lengths");

      // R8: transient with error reported early (ignored) then after injection
      arm_watch(5, 16'hACE1, 1'b1, 1'b1, '0, n);
      check(steps_for(16'hACE1) == n, "R5 step model", 32'(n), 32'(steps_for(16'hACE1)));
      pulse_err(1'b1, 5);
      query_status({4'b1110, 4'b0, 16'(n)}, "R8 released flag and count");

      // Random arming
      cur = '0;
      for (int it = 0; it < 14; it++) begin
         int idx;
         logic [15:0] seed;
         logic tr, ee;
         idx  = int'($urandom % NP);
         seed = 16'($urandom);
         while (steps_for(seed) > 3000) seed = 16'($urandom);
         tr = 1'($urandom);
         ee = 1'($urandom);
         arm_watch(idx, seed, tr, ee, cur, n);
         pulse_err(tr, idx);
         query_status({1'b1, 1'b1, tr, 1'b0, 4'b0, 16'(n)}, "R2/R5 random status");
         cur = tr ? '0 : pmask(idx);
         if ($urandom % 3 == 0) begin
            xfer(mk_frame(1'b0, 1'b0, 6'd0, 16'd0), 24, rx);
            for (int c = 1; c <= 4; c++)
               step_check(c < SYNC + 1 ? cur : '0, "R3 random disarm");
            cur = '0;
         end
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule